// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a clock synthesizer loop. It counts cycles of the loop clock and emits one pulse every N cycles, which a phase detector compares with the reference. Internally a prescaler divides by a base modulus P and, in dual-modulus mode, by P+1 while an A counter is still non-zero. A B counter counts prescaler cycles and closes the division period. A 3-bit mode code picks either one of three fixed ratios or one of five dual-modulus pairs.

Settings are checked as they arrive. An illegal dual-modulus setting raises an error flag and is never loaded. A legal new setting is taken over only when the current period ends, or when the period is restarted with the sync input. The divided output therefore never shows a shortened period.

Top module: `ndiv_top`

## Requirements
- R1: Fixed-divide codes give N = P*B with P = 1 for code 3'b000, P = 2 for 3'b001 and P = 3 for 3'b111. The A input has no effect on the period in these modes.
- R2: Dual-modulus codes give N = P*B + A with P = 2 (3'b010), 4 (3'b011), 8 (3'b100), 16 (3'b101) and 32 (3'b110).
- R3: The settings {3'b001, B=6}, {3'b010, A=0, B=6} and {3'b011, A=0, B=3} each give a pulse-to-pulse spacing of exactly 12 clock cycles.
- R4: N = 1 ({3'b000, B=1}) holds the output high on every cycle. The B counter covers B up to 8191, for example N = 8191 with {3'b000, B=8191}.
- R5: A setting is illegal when B = 0, or in dual-modulus mode when A >= P or B < A. cfgErr is high in the cycle after an illegal setting is presented and low in the cycle after a legal one. The illegal setting is never loaded, and the previous period length stays in force.
- R6: A legal new setting changes the period only at the end of the running period (the edge that raises divPulse) or at a sync.
- R7: For N >= 2, divPulse is high for exactly one clock cycle per period, and consecutive pulses are N cycles apart.
- R8: While rst is high, divPulse and cfgErr are low. The first pulse comes N edges after reset is released. If the setting present during reset is illegal, the divider starts with 3'b110, A=0, B=1 (N = 32).
- R9: syncIn restarts the period with the presented setting, or with the active one if the presented setting is illegal. divPulse is low in the cycle after a sync, and the next pulse comes N edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| syncIn | input | 1 | Synchronous period restart, active high |
| modeCode | input | 3 | Prescaler mode selection |
| aIn | input | 6 | Count of P+1 prescaler cycles per period |
| bIn | input | 13 | Count of prescaler cycles per period |
| divPulse | output | 1 | One-cycle pulse per division period |
| cfgErr | output | 1 | Presented setting is illegal |

## Verification
Directed cases cover each of the eight mode codes. They include fixed modes with a non-zero A, which separates a divider that ignores A from one that adds it. The three equivalent settings for N = 12, together with N = 1 and N = 8191, probe the ends of the counter ranges. Random settings are drawn over all codes with A up to 40, so many of them are illegal; these show whether a rejected setting leaks into the period. They are changed at random points mid-period and mixed with random syncs, which separates loading at the period boundary from loading at once.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  localparam int MODE_W = 3;
  localparam int A_W    = 6;
  localparam int B_W    = 13;
  localparam int P_W    = 6;

  typedef struct packed {
    logic [P_W-1:0] p;
    logic           dual;
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
  } divCfg_t;

  typedef struct packed {
    logic restart;
    logic boundary;
    logic reload;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [P_W-1:0] p;
    logic           dual;
  } modeDec_t;

  function automatic modeDec_t decodeMode(input logic [MODE_W-1:0] code);
    modeDec_t d;
    unique case (code)
      3'b000:  d = '{p: P_W'(1),  dual: 1'b0};
      3'b001:  d = '{p: P_W'(2),  dual: 1'b0};
      3'b010:  d = '{p: P_W'(2),  dual: 1'b1};
      3'b011:  d = '{p: P_W'(4),  dual: 1'b1};
      3'b100:  d = '{p: P_W'(8),  dual: 1'b1};
      3'b101:  d = '{p: P_W'(16), dual: 1'b1};
      3'b110:  d = '{p: P_W'(32), dual: 1'b1};
      default: d = '{p: P_W'(3),  dual: 1'b0};
    endcase
    return d;
  endfunction

  localparam divCfg_t FALLBACK_CFG = '{p: P_W'(32), dual: 1'b1, a: '0, b: B_W'(1)};
endpackage

// File: rtl/ndiv_ctrl.sv
module ndiv_ctrl
  import ndiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              syncIn,
  input  logic [MODE_W-1:0] modeCode,
  input  logic [A_W-1:0]    aIn,
  input  logic [B_W-1:0]    bIn,
  input  logic              termFlag,
  output divCfg_t           loadCfg,
  output divCfg_t           actCfg,
  output ctrlStrobe_t       strobe,
  output logic              cfgErr
);
  modeDec_t dec;
  divCfg_t  reqCfg;
  logic     reqLegal;

  always_comb begin
    dec         = decodeMode(modeCode);
    reqCfg.p    = dec.p;
    reqCfg.dual = dec.dual;
    reqCfg.a    = dec.dual ? aIn : '0;
    reqCfg.b    = bIn;
    reqLegal    = (bIn != '0) &&
                  (!dec.dual || ((P_W'(aIn) < dec.p) && (bIn >= B_W'(aIn))));
  end

  always_comb begin
    strobe.restart  = rst | syncIn;
    strobe.boundary = termFlag & ~strobe.restart;
    strobe.reload   = strobe.restart | termFlag;
    if (reqLegal)  loadCfg = reqCfg;
    else if (rst)  loadCfg = FALLBACK_CFG;
    else           loadCfg = actCfg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actCfg <= loadCfg;
      cfgErr <= 1'b0;
    end else begin
      if (strobe.reload) actCfg <= loadCfg;
      cfgErr <= ~reqLegal;
    end
  end
endmodule

// File: rtl/ndiv_count_dp.sv
module ndiv_count_dp
  import ndiv_pkg::*;
(
  input  logic        clk,
  input  ctrlStrobe_t strobe,
  input  divCfg_t     loadCfg,
  input  divCfg_t     actCfg,
  output logic        termFlag,
  output logic        divPulse
);
  logic [P_W-1:0] preCnt;
  logic [B_W-1:0] bCnt;
  logic [A_W-1:0] aLeft;
  logic [A_W-1:0] aNext;

  function automatic logic [P_W-1:0] firstPre(input logic [P_W-1:0] p,
                                               input logic [A_W-1:0] extLeft);
    return (extLeft != '0) ? p : p - P_W'(1);
  endfunction

  always_comb begin
    termFlag = (preCnt == '0) && (bCnt == '0);
    aNext    = (aLeft != '0) ? aLeft - A_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (strobe.reload) begin
      preCnt   <= firstPre(loadCfg.p, loadCfg.a);
      bCnt     <= loadCfg.b - B_W'(1);
      aLeft    <= loadCfg.a;
      divPulse <= strobe.boundary;
    end else if (preCnt == '0) begin
      preCnt   <= firstPre(actCfg.p, aNext);
      bCnt     <= bCnt - B_W'(1);
      aLeft    <= aNext;
      divPulse <= 1'b0;
    end else begin
      preCnt   <= preCnt - P_W'(1);
      divPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/ndiv_top.sv
module ndiv_top
  import ndiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              syncIn,
  input  logic [MODE_W-1:0] modeCode,
  input  logic [A_W-1:0]    aIn,
  input  logic [B_W-1:0]    bIn,
  output logic              divPulse,
  output logic              cfgErr
);
  divCfg_t     loadCfg;
  divCfg_t     actCfg;
  ctrlStrobe_t strobe;
  logic        termFlag;

  ndiv_ctrl u_ctrl (
    .clk(clk), .rst(rst), .syncIn(syncIn), .modeCode(modeCode),
    .aIn(aIn), .bIn(bIn), .termFlag(termFlag), .loadCfg(loadCfg),
    .actCfg(actCfg), .strobe(strobe), .cfgErr(cfgErr)
  );

  ndiv_count_dp u_dp (
    .clk(clk), .strobe(strobe), .loadCfg(loadCfg), .actCfg(actCfg),
    .termFlag(termFlag), .divPulse(divPulse)
  );
endmodule

// File: rtl/ndiv_chk.sv
module ndiv_chk
  import ndiv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              syncIn,
  input logic [MODE_W-1:0] modeCode,
  input logic [A_W-1:0]    aIn,
  input logic [B_W-1:0]    bIn,
  input logic              divPulse,
  input logic              cfgErr,
  input logic              termFlag,
  input divCfg_t           actCfg
);
  logic isDual;
  logic [P_W-1:0] baseP;
  logic badReq;

  always_comb begin
    isDual = (modeCode >= 3'b010) && (modeCode <= 3'b110);
    case (modeCode)
      3'b000: baseP = 6'd1;
      3'b001: baseP = 6'd2;
      3'b111: baseP = 6'd3;
      default: baseP = 6'd2 << (modeCode - 3'b010);
    endcase
    badReq = (bIn == '0) || (isDual && ((P_W'(aIn) >= baseP) || (bIn < B_W'(aIn))));
  end

  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!divPulse && !cfgErr));

  // R5
  err_flag_chk: assert property (@(posedge clk) disable iff (rst) badReq |=> cfgErr);

  // R5
  reject_keep_chk: assert property (@(posedge clk) disable iff (rst) badReq |=> $stable(actCfg));

  // R6
  hold_midperiod_chk: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && !termFlag) |=> $stable(actCfg));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (divPulse && !(actCfg.p == P_W'(1) && actCfg.b == B_W'(1))) |=> !divPulse);

  // R9
  sync_quiet_chk: assert property (@(posedge clk) disable iff (rst) syncIn |=> !divPulse);
endmodule

bind ndiv_top ndiv_chk u_chk (
  .clk(clk), .rst(rst), .syncIn(syncIn), .modeCode(modeCode), .aIn(aIn),
  .bIn(bIn), .divPulse(divPulse), .cfgErr(cfgErr), .termFlag(termFlag),
  .actCfg(actCfg)
);

// File: tb/ndiv_top_tb.sv
module ndiv_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        syncIn = 1'b0;
  logic [2:0]  modeCode = 3'b110;
  logic [5:0]  aIn = '0;
  logic [12:0] bIn = 13'd1;
  logic        divPulse;
  logic        cfgErr;

  int vecCount  = 0;
  int failCount = 0;
  int cycCount  = 0;

  int  mActN = 32;
  int  mRem  = 32;
  logic mPulse = 1'b0;
  logic mErr   = 1'b0;

  ndiv_top u_dut (
    .clk(clk), .rst(rst), .syncIn(syncIn), .modeCode(modeCode),
    .aIn(aIn), .bIn(bIn), .divPulse(divPulse), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > MAX_CYCLES) begin
      failCount++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycCount, MAX_CYCLES);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  function automatic int pOf(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b111: return 3;
      3'b010: return 2;
      3'b011: return 4;
      3'b100: return 8;
      3'b101: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic bit dualOf(input logic [2:0] c);
    return (c != 3'b000) && (c != 3'b001) && (c != 3'b111);
  endfunction

  function automatic bit legalOf(input logic [2:0] c, input int a, input int b);
    if (b == 0) return 0;
    if (dualOf(c) && (a >= pOf(c) || b < a)) return 0;
    return 1;
  endfunction

  function automatic int nOf(input logic [2:0] c, input int a, input int b);
    return pOf(c) * b + (dualOf(c) ? a : 0);
  endfunction

  task automatic tick(input string tag);
    bit leg;
    @(posedge clk);
    leg = legalOf(modeCode, int'(aIn), int'(bIn));
    if (rst) begin
      mActN = leg ? nOf(modeCode, int'(aIn), int'(bIn)) : 32;
      mRem = mActN; mPulse = 1'b0; mErr = 1'b0;
    end else if (syncIn) begin
      if (leg) mActN = nOf(modeCode, int'(aIn), int'(bIn));
      mRem = mActN; mPulse = 1'b0; mErr = !leg;
    end else if (mRem == 1) begin
      if (leg) mActN = nOf(modeCode, int'(aIn), int'(bIn));
      mRem = mActN; mPulse = 1'b1; mErr = !leg;
    end else begin
      mRem--; mPulse = 1'b0; mErr = !leg;
    end
    @(negedge clk);
    vecCount++;
    if (divPulse !== mPulse || cfgErr !== mErr) begin
      failCount++;
      $display("FAIL %s: actual pulse=%b err=%b, expected pulse=%b err=%b at cycle %0d",
               tag, divPulse, cfgErr, mPulse, mErr, cycCount);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic setCfg(input logic [2:0] c, input int a, input int b);
    modeCode = c; aIn = 6'(a); bIn = 13'(b);
  endtask

  task automatic doSync(input string tag);
    syncIn = 1'b1; tick(tag); syncIn = 1'b0;
  endtask

  // Spacing between two pulses, compared with an expected count
  task automatic checkPeriod(input int expN, input string tag);
    int gap = 0;
    int guard = 0;
    while (divPulse !== 1'b1 && guard < 4*expN + 8) begin tick(tag); guard++; end
    tick(tag); gap = 1;
    while (divPulse !== 1'b1 && gap < 4*expN + 8) begin tick(tag); gap++; end
    vecCount++;
    if (gap != expN) begin
      failCount++;
      $display("FAIL %s period: actual %0d, expected %0d", tag, gap, expN);
    end
  endtask

  initial begin
    // R8: illegal setting during reset, fallback N = 32
    setCfg(3'b010, 5, 3);
    run(3, "R8 reset");
    rst = 1'b0;
    run(70, "R8 fallback");

    // R1: fixed modes, A ignored
    setCfg(3'b000, 9, 7);  doSync("R1"); checkPeriod(7, "R1 div1");
    setCfg(3'b001, 30, 5); doSync("R1"); checkPeriod(10, "R1 div2");
    setCfg(3'b111, 63, 4); doSync("R1"); checkPeriod(12, "R1 div3");

    // R2: every dual-modulus pair
    setCfg(3'b010, 1, 3);   doSync("R2"); checkPeriod(7, "R2 2/3");
    setCfg(3'b011, 3, 5);   doSync("R2"); checkPeriod(23, "R2 4/5");
    setCfg(3'b100, 7, 7);   doSync("R2"); checkPeriod(63, "R2 8/9");
    setCfg(3'b101, 15, 20); doSync("R2"); checkPeriod(335, "R2 16/17");
    setCfg(3'b110, 31, 31); doSync("R2"); checkPeriod(1023, "R2 32/33");

    // R3: three routes to N = 12
    setCfg(3'b001, 0, 6); doSync("R3"); checkPeriod(12, "R3 fixed2");
    setCfg(3'b010, 0, 6); doSync("R3"); checkPeriod(12, "R3 2/3");
    setCfg(3'b011, 0, 3); doSync("R3"); checkPeriod(12, "R3 4/5");

    // R4: extremes
    setCfg(3'b000, 0, 1); doSync("R4"); run(10, "R4 N1");
    setCfg(3'b000, 0, 8191); doSync("R4"); checkPeriod(8191, "R4 B8191");

    // R5: illegal settings rejected, period kept
    setCfg(3'b001, 0, 9); doSync("R5");
    setCfg(3'b011, 4, 9);  run(5, "R5 A>=P");
    setCfg(3'b100, 6, 5);  run(5, "R5 B<A");
    setCfg(3'b000, 0, 0);  run(5, "R5 B0");
    checkPeriod(18, "R5 kept");
    setCfg(3'b101, 16, 40); doSync("R5 sync illegal"); checkPeriod(18, "R5 kept sync");

    // R6: mid-period change waits for boundary
    setCfg(3'b000, 0, 40); doSync("R6");
    run(10, "R6");
    setCfg(3'b000, 0, 5);
    run(29, "R6 wait");
    checkPeriod(5, "R6 new");

    // R7 and R9: random settings, random mid-period changes and syncs
    void'($urandom(32'h5EED1234));
    for (int k = 0; k < 60; k++) begin
      setCfg(3'($urandom_range(0, 7)), int'($urandom_range(0, 40)), int'($urandom_range(0, 60)));
      if ($urandom_range(0, 3) == 0) doSync("R9 random sync");
      run(int'($urandom_range(5, 400)), "R7 random");
    end

    // R8: reset in mid-run
    setCfg(3'b011, 2, 4);
    rst = 1'b1; run(2, "R8 rerun"); rst = 1'b0;
    run(60, "R8 after");

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule